// File: doc/BRIEF.md
# Serial Memory Write-Permission and Status Controller

This block holds the status register and decides write permission for a 2K x 8 serial nonvolatile memory. A command decoder outside the block turns opcodes into one-cycle strobes: arm writes, disarm writes, read status and write status. A status write also carries a data byte. The block answers each array write request in the same cycle with a grant. That grant depends on a write-enable latch and on the address range chosen by two block-protect bits. A second grant covers status writes, and it also honours the active-low protect pin.

Three status bits are nonvolatile: the protect-pin enable and the two block-protect bits. They load from `nv_init` during reset. Whenever an accepted status write changes them, the new value appears on `nv_val` together with a one-cycle `nv_upd` strobe, so a persistence layer can store it.

There is no back-pressure anywhere. Writes complete in real time, so `cmd_ready` is held high and no strobe is ever stalled or dropped. Bit 0 of the status byte is never a busy flag.

Top module: `spi_wprot_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the enable latch clears to 0 and the nonvolatile bits load from `nv_init`. Packing is [2]=pin-enable, [1]=BP1, [0]=BP0. `stat_valid` and `nv_upd` are 0 after reset.
- R2: `cmd_wren` sets the enable latch at the next edge. `cmd_wrdi` clears it. A clear event in the same cycle wins over `cmd_wren`.
- R3: `arr_wr_grant` is combinational and equals `arr_wr_req` AND latch AND NOT protected(`arr_addr`).
- R4: Protection uses only `arr_addr[10:9]`. BP=00 protects nothing. BP=01 protects 0x600-0x7FF. BP=10 protects 0x400-0x7FF. BP=11 protects everything.
- R5: A granted array write arms a pending clear. At the first clock edge where `cs_n` is high after the grant, the latch clears. A refused array write leaves the latch unchanged.
- R6: `sr_wr_grant` is 0 whenever the pin-enable bit is 1 and `wp_n` is 0. With pin-enable at 0, `wp_n` is ignored. `wp_n` never affects `arr_wr_grant`.
- R7: `sr_wr_grant` = `cmd_wrsr` AND latch AND NOT pin-block. On a grant, `wr_data[7]` loads pin-enable and `wr_data[3:2]` load BP1:BP0 at the next edge. The other data bits are ignored, including the latch bit `wr_data[1]`. The latch clears at that same edge.
- R8: One cycle after `cmd_rdsr`, `stat_valid` is high for one cycle. `stat_byte` then holds the status as it was in the `cmd_rdsr` cycle: bit 7 is pin-enable, bit 3 is BP1, bit 2 is BP0, bit 1 is the latch, and bits 6:4 and 0 are 0.
- R9: `nv_upd` pulses in the cycle after an accepted status write that changes the nonvolatile bits, and never otherwise. `nv_val` always shows the current bits.
- R10: `cmd_ready` is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wren | input | 1 | Arm-writes strobe |
| cmd_wrdi | input | 1 | Disarm-writes strobe |
| cmd_rdsr | input | 1 | Read-status strobe |
| cmd_wrsr | input | 1 | Write-status strobe |
| wr_data | input | 8 | Data byte for a status write |
| wp_n | input | 1 | Active-low write-protect pin |
| cs_n | input | 1 | Chip select, high ends an operation |
| arr_wr_req | input | 1 | Array write request |
| arr_addr | input | 11 | Array write address |
| nv_init | input | 3 | Stored nonvolatile bits loaded at reset |
| cmd_ready | output | 1 | Always high, no stalls |
| arr_wr_grant | output | 1 | Array write permitted |
| sr_wr_grant | output | 1 | Status write permitted |
| stat_valid | output | 1 | Status byte valid |
| stat_byte | output | 8 | Status byte snapshot |
| nv_upd | output | 1 | Nonvolatile bits changed |
| nv_val | output | 3 | Current nonvolatile bits |

## Verification
A latch stuck in the wrong state shows up in the same cycle as a wrong `arr_wr_grant` or `sr_wr_grant`, and one cycle after any status read as bit 1 of `stat_byte`. Corrupted block-protect or pin-enable bits are visible at once on `nv_val`. They change the grant pattern for upper addresses, and they decide whether `wp_n` has any effect. A pending-clear flag that is missed or stuck appears on the first cycle after `cs_n` rises: a following array write is wrongly granted or wrongly refused.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  localparam int ADDR_W = 11;
  localparam int STAT_W = 8;
  localparam int PIN_EN_BIT = 7;
  localparam int BP1_BIT = 3;
  localparam int BP0_BIT = 2;
  localparam int LATCH_BIT = 1;

  typedef struct packed {
    logic       pin_en;
    logic [1:0] bp;
  } nv_cfg_t;

  function automatic logic [STAT_W-1:0] pack_status(nv_cfg_t c, logic latch);
    logic [STAT_W-1:0] b;
    b = '0;
    b[PIN_EN_BIT] = c.pin_en;
    b[BP1_BIT] = c.bp[1];
    b[BP0_BIT] = c.bp[0];
    b[LATCH_BIT] = latch;
    return b;
  endfunction
endpackage

// File: rtl/wp_range_guard.sv
module wp_range_guard #(
  parameter int ADDR_W = 11
) (
  input  logic [1:0]        bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);
  logic [1:0] top2;
  logic [2:0] thr;
  logic [ADDR_W-3:0] unused_low;

  assign top2 = addr_i[ADDR_W-1:ADDR_W-2];
  assign unused_low = addr_i[ADDR_W-3:0];

  // lowest protected quarter index for each block-protect code
  always_comb begin
    case (bp_i)
      2'b00:   thr = 3'd4;
      2'b01:   thr = 3'd3;
      2'b10:   thr = 3'd2;
      default: thr = 3'd0;
    endcase
  end

  assign prot_o = ({1'b0, top2} >= thr);
endmodule

// File: rtl/wp_enable_latch.sv
module wp_enable_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic wren_i,
  input  logic wrdi_i,
  input  logic sr_grant_i,
  input  logic arr_grant_i,
  input  logic cs_n_i,
  output logic latch_o
);
  logic pend_q;
  logic close_evt;
  logic clr_evt;

  assign close_evt = pend_q & cs_n_i;
  assign clr_evt   = wrdi_i | sr_grant_i | close_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_o <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (clr_evt)     latch_o <= 1'b0;
      else if (wren_i) latch_o <= 1'b1;
      if (arr_grant_i)  pend_q <= 1'b1;
      else if (cs_n_i)  pend_q <= 1'b0;
    end
  end

  p_wel_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wren_i && !clr_evt) |=> latch_o);
  p_wel_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrdi_i |=> !latch_o);
  p_arm_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cs_n_i) |=> !latch_o);
  p_pend_needs_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(arr_grant_i));
endmodule

// File: rtl/wp_cfg_reg.sv
module wp_cfg_reg
  import wprot_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  nv_cfg_t init_i,
  input  logic    wr_i,
  input  nv_cfg_t data_i,
  output nv_cfg_t cfg_o,
  output logic    upd_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_o <= init_i;
      upd_o <= 1'b0;
    end else begin
      upd_o <= wr_i && (data_i != cfg_o);
      if (wr_i) cfg_o <= data_i;
    end
  end

  p_upd_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> $past(wr_i));
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(cfg_o));
endmodule

// File: rtl/spi_wprot_ctrl.sv
module spi_wprot_ctrl
  import wprot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_rdsr,
  input  logic              cmd_wrsr,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              wp_n,
  input  logic              cs_n,
  input  logic              arr_wr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic [2:0]        nv_init,
  output logic              cmd_ready,
  output logic              arr_wr_grant,
  output logic              sr_wr_grant,
  output logic              stat_valid,
  output logic [STAT_W-1:0] stat_byte,
  output logic              nv_upd,
  output logic [2:0]        nv_val
);
  nv_cfg_t cfg;
  nv_cfg_t cfg_wdata;
  logic    latch;
  logic    prot;
  logic    pin_block;
  logic [4:0] unused_wr_bits;

  assign cmd_ready = 1'b1;

  assign cfg_wdata.pin_en = wr_data[PIN_EN_BIT];
  assign cfg_wdata.bp     = {wr_data[BP1_BIT], wr_data[BP0_BIT]};
  assign unused_wr_bits   = {wr_data[6:4], wr_data[LATCH_BIT], wr_data[0]};

  wp_range_guard #(.ADDR_W(ADDR_W)) u_guard (
    .bp_i   (cfg.bp),
    .addr_i (arr_addr),
    .prot_o (prot)
  );

  assign pin_block    = cfg.pin_en & ~wp_n;
  assign arr_wr_grant = arr_wr_req & latch & ~prot;
  assign sr_wr_grant  = cmd_wrsr & latch & ~pin_block;

  wp_enable_latch u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .wren_i      (cmd_wren),
    .wrdi_i      (cmd_wrdi),
    .sr_grant_i  (sr_wr_grant),
    .arr_grant_i (arr_wr_grant),
    .cs_n_i      (cs_n),
    .latch_o     (latch)
  );

  wp_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .init_i (nv_cfg_t'(nv_init)),
    .wr_i   (sr_wr_grant),
    .data_i (cfg_wdata),
    .cfg_o  (cfg),
    .upd_o  (nv_upd)
  );

  assign nv_val = cfg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_valid <= 1'b0;
      stat_byte  <= '0;
    end else begin
      stat_valid <= cmd_rdsr;
      if (cmd_rdsr) stat_byte <= pack_status(cfg, latch);
    end
  end

  p_arr_needs_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_grant |-> latch);
  p_full_protect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.bp == 2'b11) |-> !arr_wr_grant);
  p_pin_blocks_sr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.pin_en && !wp_n) |-> !sr_wr_grant);
  p_sr_clears_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_grant |=> !latch);
  p_rdsr_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rdsr |=> stat_valid);
  p_fixed_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_byte[6:4] == 3'b000 && stat_byte[0] == 1'b0));
endmodule

// File: tb/spi_wprot_ctrl_test.sv
module spi_wprot_ctrl_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cmd_wren, cmd_wrdi, cmd_rdsr, cmd_wrsr, wp_n, cs_n, arr_wr_req;
  logic [7:0]  wr_data;
  logic [10:0] arr_addr;
  logic [2:0]  nv_init;
  logic cmd_ready, arr_wr_grant, sr_wr_grant, stat_valid, nv_upd;
  logic [7:0] stat_byte;
  logic [2:0] nv_val;

  spi_wprot_ctrl uut (.*);

  int n_tests = 0;
  int n_fail  = 0;
  logic       m_wel, m_pend;
  logic [2:0] m_cfg;

  function automatic logic m_prot(logic [1:0] bp, logic [10:0] a);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a >= 11'h600;
      2'b10:   return a >= 11'h400;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] m_byte(logic [2:0] c, logic w);
    return {c[2], 3'b000, c[1], c[0], w, 1'b0};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic wren, logic wrdi, logic rdsr, logic wrsr, logic [7:0] d,
                      logic wp, logic cs, logic req, logic [10:0] a);
    logic eag, esg, eupd, clr;
    logic [2:0] ncfg;
    logic [7:0] ebyte;
    @(negedge clk);
    cmd_wren = wren; cmd_wrdi = wrdi; cmd_rdsr = rdsr; cmd_wrsr = wrsr;
    wr_data = d; wp_n = wp; cs_n = cs; arr_wr_req = req; arr_addr = a;
    #1;
    eag = req & m_wel & ~m_prot(m_cfg[1:0], a);
    esg = wrsr & m_wel & ~(m_cfg[2] & ~wp);
    chk("R3/R4/R5 arr_wr_grant", 32'(arr_wr_grant), 32'(eag));
    chk("R6/R7 sr_wr_grant", 32'(sr_wr_grant), 32'(esg));
    chk("R10 cmd_ready", 32'(cmd_ready), 32'd1);
    ebyte = m_byte(m_cfg, m_wel);
    ncfg = esg ? {d[7], d[3], d[2]} : m_cfg;
    eupd = esg && (ncfg != m_cfg);
    clr = esg | wrdi | (m_pend & cs);
    @(posedge clk);
    if (clr) m_wel = 1'b0; else if (wren) m_wel = 1'b1;
    if (eag) m_pend = 1'b1; else if (cs) m_pend = 1'b0;
    m_cfg = ncfg;
    #1;
    chk("R8 stat_valid", 32'(stat_valid), 32'(rdsr));
    if (rdsr) chk("R8 stat_byte", 32'(stat_byte), 32'(ebyte));
    chk("R9 nv_upd", 32'(nv_upd), 32'(eupd));
    chk("R9 nv_val", 32'(nv_val), 32'(m_cfg));
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 8'h00, 1, 1, 0, 11'h0);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 0; cmd_wren = 0; cmd_wrdi = 0; cmd_rdsr = 0; cmd_wrsr = 0;
    wr_data = 0; wp_n = 1; cs_n = 1; arr_wr_req = 0; arr_addr = 0;
    nv_init = 3'b101;
    repeat (3) @(posedge clk);
    m_wel = 0; m_pend = 0; m_cfg = nv_init;
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 nv_val", 32'(nv_val), 32'h5);
    chk("R1 stat_valid", 32'(stat_valid), 32'h0);
    chk("R1 nv_upd", 32'(nv_upd), 32'h0);
    step(0, 0, 1, 0, 8'h00, 1, 1, 0, 11'h0);
    chk("R1 R8 status after reset", 32'(stat_byte), 32'h84);
    // R7 write without latch refused
    step(0, 0, 0, 1, 8'h00, 1, 1, 0, 11'h0);
    // R6 pin-enable=1, pin low blocks
    step(1, 0, 0, 0, 8'h00, 1, 1, 0, 11'h0);
    step(0, 0, 0, 1, 8'h00, 0, 1, 0, 11'h0);
    // R7 with pin high: write 0x7F, ignored bits, latch bit not settable
    step(0, 0, 0, 1, 8'h7F, 1, 1, 0, 11'h0);
    step(0, 0, 1, 0, 8'h00, 1, 1, 0, 11'h0);
    chk("R7 ignored bits", 32'(stat_byte), 32'h0C);
    // R4 walk BP values, R5 close on cs_n
    for (int bp = 0; bp < 4; bp++) begin
      step(1, 0, 0, 0, 8'h00, 1, 1, 0, 11'h0);
      step(0, 0, 0, 1, 8'(bp << 2), 1, 1, 0, 11'h0);
      for (int q = 0; q < 4; q++) begin
        step(1, 0, 0, 0, 8'h00, 1, 1, 0, 11'h0);
        step(0, 0, 0, 0, 8'h00, q[0], 0, 1, 11'(q * 11'h200 + 11'h1FF));
        step(0, 0, 0, 0, 8'h00, 1, 0, 0, 11'h0);
        step(0, 0, 1, 0, 8'h00, 1, 1, 0, 11'h0);
        step(0, 0, 1, 0, 8'h00, 1, 1, 0, 11'h0);
      end
    end
    // R2 wren with wrdi: clear wins
    step(1, 1, 0, 0, 8'h00, 1, 1, 0, 11'h0);
    step(0, 0, 1, 0, 8'h00, 1, 1, 0, 11'h0);
    chk("R2 clear wins", 32'(stat_byte[1]), 32'h0);
    // R6 pin ignored with pin-enable 0
    step(1, 0, 0, 0, 8'h00, 1, 1, 0, 11'h0);
    step(0, 0, 0, 1, 8'h00, 0, 1, 0, 11'h0);
    chk("R6 pin ignored", 32'(nv_val), 32'h0);
    // random phase
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      logic w, dd, rs, ws, rq;
      r = $urandom;
      w  = (r[2:0] < 3);
      dd = (r[2:0] == 3);
      rs = (r[2:0] == 4);
      ws = (r[2:0] == 5);
      rq = r[4:3] != 0;
      step(w, dd, rs, ws, r[15:8], r[16] | r[17], rq ? 1'b0 : (r[19:18] == 0),
           rq, r[30:20]);
    end
    idle();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule